// File: doc/BRIEF.md
# Serial Order Field Capture Register

This block assembles a 5-bit order field from a serial pulse train. A digit-time counter, advanced by a digit tick and restarted by a word-start strobe, opens one capture slot for each of the last five digit times of a 36-digit word. A field flag is set when the order train is high during that flag's own slot. Once set, the flag stays set until the block clears it.

Each flag drives a true rail and a complement rail. The complement rail is the inverse of the single stored state. One chosen bit has both of its rails held low until the final slot of the field has been taken. A decoder built on these rails therefore cannot match any code while the flags are still filling. A sticky qualify flag records that the final slot has passed, and the ready output shows it.

All flags and the qualify flag are cleared by a one-cycle pulse. The pulse follows a cycle in which the gating input falls while the end pulse is high. The same pulse is driven out so that a companion address-capture unit clears in step with this one. The block uses one clock and an active-low asynchronous reset.

Top module: `order_field_capture`

## Requirements
- R1: The digit counter is 0 after reset and after any cycle with `word_start_i` high. In every other cycle with `tick_i` high it advances by one, and 35 wraps to 0. Bit k of `slot_o` is high in exactly those cycles where `tick_i` is high and the counter equals 31+k.
- R2: Field bit k is set at the clock edge that ends a cycle in which `slot_o[k]` and `order_i` are both high.
- R3: A high `order_i` outside a field bit's own slot leaves that bit unchanged.
- R4: A set field bit stays set until a clear pulse.
- R5: For every bit except bit 3, `pos_o[k]` equals the stored bit and `neg_o[k]` is its inverse.
- R6: For bit 3, `pos_o[3]` and `neg_o[3]` are both 0 while `ready_o` is 0. While `ready_o` is 1 they follow the stored bit as in R5.
- R7: `ready_o` goes to 1 at the edge that ends a cycle with `slot_o[4]` high, and it stays at 1 until a clear pulse.
- R8: `clear_o` is high for exactly one cycle after a cycle in which `gate_i` was high on the previous cycle, `gate_i` is low now and `end_i` is high. Every field bit and `ready_o` are 0 after the edge that ends the `clear_o` cycle.
- R9: A falling `gate_i` while `end_i` is low, or `end_i` high with no falling `gate_i`, produces no clear pulse.
- R10: In a cycle with `clear_o` high, a slot capture or a final-slot qualify has no effect.
- R11: After reset, `pos_o` is all 0, `neg_o` is 1 on every bit except bit 3, and `ready_o` and `clear_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_start_i | input | 1 | Restarts the digit counter at digit 0 |
| tick_i | input | 1 | Digit tick; a high cycle is one digit time |
| order_i | input | 1 | Serial order pulse train |
| gate_i | input | 1 | Gating level whose falling edge can clear |
| end_i | input | 1 | End pulse that qualifies the clear |
| slot_o | output | 5 | One-hot capture slot strobes for digits 31 to 35 |
| pos_o | output | 5 | True rails of the field flags |
| neg_o | output | 5 | Complement rails of the field flags |
| ready_o | output | 1 | Field complete; the gated bit is valid |
| clear_o | output | 1 | Shared one-cycle clear pulse |

## Verification
The assertions assume that all inputs are synchronous to the clock and stable around its edge. They assume that the digit tick is the only thing that moves the counter, and that a word start may arrive at any time, including during a slot. The bench drives every input on the falling clock edge. It builds each word from ticks with random idle gaps, random order bits and random gating, and mixes in directed cases where a clear meets a capture or a qualify in the same cycle.

// File: rtl/ofc_pkg.sv
package ofc_pkg;
  localparam int unsigned FIELD_W     = 5;
  localparam int unsigned FIRST_DIGIT = 31;
  localparam int unsigned WORD_DIGITS = 36;
  localparam int unsigned GATED_IDX   = 3;
endpackage

// File: rtl/ofc_digit_timer.sv
module ofc_digit_timer #(
  parameter int unsigned WORD_DIGITS = 36,
  parameter int unsigned FIRST_DIGIT = 31,
  parameter int unsigned FIELD_W     = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               word_start_i,
  input  logic               tick_i,
  output logic [FIELD_W-1:0] slot_o,
  output logic               last_o
);
  localparam int unsigned CNT_W = $clog2(WORD_DIGITS);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WORD_DIGITS - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (word_start_i)  cnt_q <= '0;
    else if (tick_i)        cnt_q <= (cnt_q == LAST_CNT) ? '0 : cnt_q + 1'b1;
  end

  for (genvar k = 0; k < FIELD_W; k++) begin : g_slot
    localparam logic [CNT_W-1:0] SLOT_CNT = CNT_W'(FIRST_DIGIT + k);
    assign slot_o[k] = tick_i && (cnt_q == SLOT_CNT);
  end

  assign last_o = slot_o[FIELD_W-1];

  a_r1_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST_CNT);
  a_r1_slot_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(slot_o));
  a_r1_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !word_start_i && cnt_q == LAST_CNT) |=> cnt_q == '0);
endmodule

// File: rtl/ofc_clear_gen.sv
module ofc_clear_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_i,
  input  logic end_i,
  output logic clear_o
);
  logic gate_q, clear_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q  <= 1'b0;
      clear_q <= 1'b0;
    end else begin
      gate_q  <= gate_i;
      clear_q <= gate_q && !gate_i && end_i;
    end
  end

  assign clear_o = clear_q;

  a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_o |=> !clear_o);
  a_r9_needs_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !end_i |=> !clear_o);
endmodule

// File: rtl/ofc_flag_bank.sv
module ofc_flag_bank #(
  parameter int unsigned FIELD_W   = 5,
  parameter int unsigned GATED_IDX = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [FIELD_W-1:0] slot_i,
  input  logic               order_i,
  input  logic               last_i,
  input  logic               clear_i,
  output logic [FIELD_W-1:0] pos_o,
  output logic [FIELD_W-1:0] neg_o,
  output logic               ready_o
);
  logic [FIELD_W-1:0] flag_q;
  logic               qual_q;

  // clear wins over set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      qual_q <= 1'b0;
    else if (clear_i) qual_q <= 1'b0;
    else if (last_i)  qual_q <= 1'b1;
  end

  for (genvar k = 0; k < FIELD_W; k++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     flag_q[k] <= 1'b0;
      else if (clear_i)                flag_q[k] <= 1'b0;
      else if (slot_i[k] && order_i)   flag_q[k] <= 1'b1;
    end

    if (k == GATED_IDX) begin : g_gated
      assign pos_o[k] = flag_q[k] && qual_q;
      assign neg_o[k] = !flag_q[k] && qual_q;
    end else begin : g_plain
      assign pos_o[k] = flag_q[k];
      assign neg_o[k] = !flag_q[k];
    end

    a_r3_set_in_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_q[k]) |-> $past(slot_i[k] && order_i));
    a_r4_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[k] && !clear_i) |=> flag_q[k]);
  end

  assign ready_o = qual_q;

  a_r8_clear_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (flag_q == '0) && !ready_o);
  a_r7_ready_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(last_i));
  a_r6_gated_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> !pos_o[GATED_IDX] && !neg_o[GATED_IDX]);
  a_r5_rails_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_o & neg_o) == '0);
endmodule

// File: rtl/order_field_capture.sv
module order_field_capture
  import ofc_pkg::*;
#(
  parameter int unsigned P_FIELD_W     = FIELD_W,
  parameter int unsigned P_FIRST_DIGIT = FIRST_DIGIT,
  parameter int unsigned P_WORD_DIGITS = WORD_DIGITS,
  parameter int unsigned P_GATED_IDX   = GATED_IDX
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 word_start_i,
  input  logic                 tick_i,
  input  logic                 order_i,
  input  logic                 gate_i,
  input  logic                 end_i,
  output logic [P_FIELD_W-1:0] slot_o,
  output logic [P_FIELD_W-1:0] pos_o,
  output logic [P_FIELD_W-1:0] neg_o,
  output logic                 ready_o,
  output logic                 clear_o
);
  logic last_slot;
  logic clear_pulse;

  ofc_digit_timer #(
    .WORD_DIGITS(P_WORD_DIGITS),
    .FIRST_DIGIT(P_FIRST_DIGIT),
    .FIELD_W    (P_FIELD_W)
  ) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .word_start_i(word_start_i),
    .tick_i      (tick_i),
    .slot_o      (slot_o),
    .last_o      (last_slot)
  );

  ofc_clear_gen u_clear (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .gate_i (gate_i),
    .end_i  (end_i),
    .clear_o(clear_pulse)
  );

  ofc_flag_bank #(
    .FIELD_W  (P_FIELD_W),
    .GATED_IDX(P_GATED_IDX)
  ) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .slot_i (slot_o),
    .order_i(order_i),
    .last_i (last_slot),
    .clear_i(clear_pulse),
    .pos_o  (pos_o),
    .neg_o  (neg_o),
    .ready_o(ready_o)
  );

  assign clear_o = clear_pulse;

  a_r10_clear_beats_qualify: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_o && last_slot) |=> !ready_o);
endmodule

// File: tb/order_field_capture_test.sv
`timescale 1ns/1ps
module order_field_capture_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ws = 1'b0, tk = 1'b0, ob = 1'b0, gt = 1'b0, ep = 1'b0;
  logic [4:0] slot, pos, neg;
  logic ready, clr;

  int n_chk = 0, n_err = 0;

  int         m_cnt;
  logic [4:0] m_flag;
  logic       m_qual, m_clr, m_gprev;

  always #2.5 clk = ~clk;

  order_field_capture uut (
    .clk_i(clk), .rst_ni(rst_n), .word_start_i(ws), .tick_i(tk), .order_i(ob),
    .gate_i(gt), .end_i(ep), .slot_o(slot), .pos_o(pos), .neg_o(neg),
    .ready_o(ready), .clear_o(clr)
  );

  function automatic logic [4:0] exp_pos();
    logic [4:0] p = m_flag;
    p[3] = m_flag[3] & m_qual;
    return p;
  endfunction

  function automatic logic [4:0] exp_neg();
    logic [4:0] n = ~m_flag;
    n[3] = ~m_flag[3] & m_qual;
    return n;
  endfunction

  function automatic logic [4:0] exp_slot();
    logic [4:0] s = '0;
    if (tk && m_cnt >= 31 && m_cnt <= 35) s[m_cnt-31] = 1'b1;
    return s;
  endfunction

  task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%b exp=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_outs(input string tag);
    chk({tag, " R2 R5 R6 pos"}, pos, exp_pos());
    chk({tag, " R5 R6 neg"}, neg, exp_neg());
    chk({tag, " R7 ready"}, {4'b0, ready}, {4'b0, m_qual});
    chk({tag, " R8 R9 clear"}, {4'b0, clr}, {4'b0, m_clr});
  endtask

  task automatic model_reset();
    m_cnt = 0; m_flag = '0; m_qual = 1'b0; m_clr = 1'b0; m_gprev = 1'b0;
  endtask

  task automatic step(input logic w, input logic t, input logic b,
                      input logic g, input logic e, input string tag);
    logic [4:0] s;
    logic       nclr;
    @(negedge clk);
    ws = w; tk = t; ob = b; gt = g; ep = e;
    #1;
    s = exp_slot();
    chk({tag, " R1 slot"}, slot, s);
    nclr = m_gprev & ~g & e;
    if (m_clr) begin
      m_flag = '0; m_qual = 1'b0;
    end else begin
      if (b) m_flag = m_flag | s;
      if (s[4]) m_qual = 1'b1;
    end
    m_clr = nclr;
    m_gprev = g;
    if (w) m_cnt = 0;
    else if (t) m_cnt = (m_cnt == 35) ? 0 : m_cnt + 1;
    @(posedge clk);
    #1;
    check_outs(tag);
  endtask

  initial begin
    #(200000 * 5);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    int seed;
    logic bits [5];
    seed = 32'h5eed_0c0d;
    void'($urandom(seed));
    model_reset();
    #7;
    check_outs("R11 reset");
    @(negedge clk); rst_n = 1'b1;

    // directed: a full word of all-ones, check gated bit hidden until last slot
    step(1, 0, 0, 0, 0, "R1 word start");
    for (int i = 0; i < 31; i++) step(0, 1, 1, 0, 0, "R3 order outside slot");
    chk("R3 nothing set before slots", pos, 5'b00000);
    for (int i = 0; i < 4; i++) step(0, 1, 1, 0, 0, "R2 fill");
    chk("R6 gated rails low before last", {3'b0, pos[3], neg[3]}, 5'b0);
    step(0, 1, 1, 0, 0, "R7 last slot");
    chk("R7 ready after last", {4'b0, ready}, 5'b1);
    chk("R1 wrap to digit 0", slot, 5'b0);
    for (int i = 0; i < 5; i++) step(0, 0, 1, 0, 0, "R4 hold");
    chk("R4 sticky flags", pos, 5'b11111);

    // R9: falling gate without end pulse, end pulse without edge
    step(0, 0, 0, 1, 0, "R9 gate up");
    step(0, 0, 0, 0, 0, "R9 fall no end");
    step(0, 0, 0, 0, 1, "R9 end no edge");
    step(0, 0, 0, 0, 0, "R9 idle");
    chk("R9 flags kept", pos, 5'b11111);
    // R8 real clear
    step(0, 0, 0, 1, 0, "R8 gate up");
    step(0, 0, 0, 0, 1, "R8 fall with end");
    chk("R8 clear pulse", {4'b0, clr}, 5'b1);
    step(0, 0, 0, 0, 0, "R8 cleared");
    chk("R8 flags cleared", pos, 5'b0);

    // R10: clear coincides with slot 0 capture
    step(1, 0, 0, 1, 0, "R10 restart");
    for (int i = 0; i < 30; i++) step(0, 1, 0, 1, 0, "R10 advance");
    step(0, 1, 0, 0, 1, "R10 fall");
    step(0, 1, 1, 0, 0, "R10 clear vs set");
    chk("R10 set blocked by clear", {4'b0, pos[0]}, 5'b0);
    // R10: clear coincides with last-slot qualify
    for (int i = 0; i < 3; i++) step(0, 1, 1, 1, 0, "R10 fill");
    step(0, 0, 0, 0, 1, "R10 fall2");
    step(0, 1, 1, 0, 0, "R10 clear vs qualify");
    chk("R10 qualify blocked by clear", {4'b0, ready}, 5'b0);

    // random words
    for (int w = 0; w < 60; w++) begin
      for (int k = 0; k < 5; k++) bits[k] = 1'($urandom_range(0, 1));
      step(1, 0, 0, gt, 0, "rnd start");
      for (int d = 0; d < 36; d++) begin
        logic g, e, b;
        while ($urandom_range(0, 3) == 0) begin
          g = ($urandom_range(0, 9) == 0) ? ~gt : gt;
          step(0, 0, 1'($urandom_range(0, 1)), g, 1'($urandom_range(0, 5) == 0), "rnd idle");
        end
        g = ($urandom_range(0, 19) == 0) ? ~gt : gt;
        e = ($urandom_range(0, 7) == 0);
        b = (d >= 31) ? bits[d-31] : 1'($urandom_range(0, 1));
        step(0, 1, b, g, e, "rnd tick");
      end
      for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0, "rnd tail");
      step(0, 0, 0, 0, 1, "rnd clear");
      step(0, 0, 0, 0, 0, "rnd after");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule